// File: doc/BRIEF.md
# Four-Bit Register-Register ALU with Flag Holder

This block is the execute stage for the register-register instruction class of a small four-bit processor. Two signed operands arrive from the register file, and the low nibble of the instruction acts as a function code that picks an operation: add, subtract, AND, OR, XOR, signed multiply or compare. The block returns the computed value, a write-enable for the destination register, and four status flags: zero, negative, carry and overflow. All arithmetic uses two's complement.

The value path and the flag path are purely combinational. A small register holds the flags. It captures the flag vector on every clock edge where an ALU instruction with a defined function code is executed. Compare updates only the flags and never asserts write-enable. Function codes with no defined operation act as no-operations: nothing is written and the held flags stay as they were. The operand width is a parameter, and the function encoding is fixed.

Top module: `nib_alu`

## Requirements
- R1: Function code 0x0 adds op_a and op_b and gives the sum modulo 2^W. Carry is the unsigned carry out. Overflow is set when both operands share a sign and the sum's sign differs from it.
- R2: Function code 0x1 gives op_a minus op_b modulo 2^W. Carry is set when a borrow occurs (op_a < op_b read as unsigned). Overflow is set when the operand signs differ and the result's sign differs from op_a's sign.
- R3: Function codes 0x2, 0x3 and 0x4 give bitwise AND, OR and XOR. Carry and overflow are both 0 for these codes.
- R4: Function code 0x5 gives the low W bits of the signed product of op_a and op_b. Overflow is set when the full product lies outside the signed W-bit range. Carry is 0.
- R5: Function code 0x7 (compare) computes op_a minus op_b with the flag rules of R2 and presents that difference on result. It never asserts wr_en.
- R6: For every defined code, zero is 1 exactly when result is 0, and negative equals the most significant bit of result. The flag vector bit positions are: bit 0 zero, bit 1 negative, bit 2 carry, bit 3 overflow.
- R7: wr_en is 1 only when exec_en is 1 and the code is one of 0x0 to 0x5.
- R8: At a rising clock edge where exec_en is 1 and the code is defined (0x0 to 0x5 or 0x7), flags_q takes the value flags_now had before that edge.
- R9: Undefined codes (0x6 and 0x8 to 0xF) drive result and flags_now to 0. On such codes, and whenever exec_en is 0, flags_q keeps its value across the edge.
- R10: While rst_n is low, flags_q is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag holder |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_en | input | 1 | An ALU instruction executes this cycle |
| func | input | 4 | Function code from the instruction's low nibble |
| op_a | input | W | First source register value |
| op_b | input | W | Second source register value |
| result | output | W | Computed value |
| wr_en | output | 1 | Destination register write strobe |
| flags_now | output | 4 | Flags of the current operation {V,C,N,Z} |
| flags_q | output | 4 | Held flags {V,C,N,Z} |

## Verification
The bench builds the block with its default width of four bits. At that width the whole input space is small enough to cover every pair of operands under all sixteen function codes, with exec_en toggling in an irregular pattern. Every overflow edge is therefore reached: the extreme signed values for add and subtract, the products −8×−1 and −8×−8 for multiply, and borrow on equal and unequal operands. The held-flag register is checked after each of those steps, so both capture and hold are exercised on defined codes, on undefined codes and with exec_en at 0.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
    localparam int FUNC_W = 4;

    localparam logic [FUNC_W-1:0] FN_ADD = 4'h0;
    localparam logic [FUNC_W-1:0] FN_SUB = 4'h1;
    localparam logic [FUNC_W-1:0] FN_AND = 4'h2;
    localparam logic [FUNC_W-1:0] FN_OR  = 4'h3;
    localparam logic [FUNC_W-1:0] FN_XOR = 4'h4;
    localparam logic [FUNC_W-1:0] FN_MUL = 4'h5;
    localparam logic [FUNC_W-1:0] FN_CMP = 4'h7;

    typedef enum logic [1:0] {
        BIT_AND = 2'd0,
        BIT_OR  = 2'd1,
        BIT_XOR = 2'd2
    } bitop_e;

    // Packed so that zero sits at bit 0 and overflow at bit 3.
    typedef struct packed {
        logic v;
        logic c;
        logic n;
        logic z;
    } flag_t;
endpackage

// File: rtl/nib_alu_addsub.sv
module nib_alu_addsub #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W:0]   cy;
    logic [W-1:0] b_eff;

    assign cy[0] = sub;

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        assign b_eff[gi]  = b[gi] ^ sub;
        assign sum[gi]    = a[gi] ^ b_eff[gi] ^ cy[gi];
        assign cy[gi + 1] = (a[gi] & b_eff[gi]) | (cy[gi] & (a[gi] ^ b_eff[gi]));
    end

    assign cout = cy[W];
    assign ovf  = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
endmodule

// File: rtl/nib_alu_mul.sv
module nib_alu_mul #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod_lo,
    output logic         ovf
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] a_ext;
    logic signed [PW-1:0] b_ext;
    logic signed [PW-1:0] prod;
    logic [PW-W:0]        upper;

    assign a_ext   = $signed({{W{a[W-1]}}, a});
    assign b_ext   = $signed({{W{b[W-1]}}, b});
    assign prod    = a_ext * b_ext;
    assign prod_lo = prod[W-1:0];
    assign upper   = prod[PW-1:W-1];
    // The product fits only if the top bits all copy the result sign.
    assign ovf     = !((&upper) || (~|upper));
endmodule

// File: rtl/nib_alu_logic.sv
module nib_alu_logic #(
    parameter int W = 4
) (
    input  logic [W-1:0]         a,
    input  logic [W-1:0]         b,
    input  nib_alu_pkg::bitop_e  sel,
    output logic [W-1:0]         y
);
    import nib_alu_pkg::*;

    always_comb begin
        unique case (sel)
            BIT_AND: y = a & b;
            BIT_OR:  y = a | b;
            BIT_XOR: y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/nib_alu.sv
module nib_alu #(
    parameter int W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          exec_en,
    input  logic [nib_alu_pkg::FUNC_W-1:0] func,
    input  logic [W-1:0]                  op_a,
    input  logic [W-1:0]                  op_b,
    output logic [W-1:0]                  result,
    output logic                          wr_en,
    output logic [3:0]                    flags_now,
    output logic [3:0]                    flags_q
);
    import nib_alu_pkg::*;

    typedef struct packed {
        logic [W-1:0] res;
        logic         writes;
        logic         defined;
        flag_t        fl;
    } exec_t;

    logic [W-1:0] as_sum;
    logic         as_cout;
    logic         as_ovf;
    logic         as_sub;
    logic [W-1:0] mul_lo;
    logic         mul_ovf;
    logic [W-1:0] lg_y;
    bitop_e       lg_sel;

    exec_t ex;
    flag_t flags_d;
    flag_t flg_q;

    assign as_sub = (func != FN_ADD);

    always_comb begin
        unique case (func)
            FN_OR:   lg_sel = BIT_OR;
            FN_XOR:  lg_sel = BIT_XOR;
            default: lg_sel = BIT_AND;
        endcase
    end

    nib_alu_addsub #(.W(W)) u_addsub (
        .a    (op_a),
        .b    (op_b),
        .sub  (as_sub),
        .sum  (as_sum),
        .cout (as_cout),
        .ovf  (as_ovf)
    );

    nib_alu_mul #(.W(W)) u_mul (
        .a       (op_a),
        .b       (op_b),
        .prod_lo (mul_lo),
        .ovf     (mul_ovf)
    );

    nib_alu_logic #(.W(W)) u_logic (
        .a   (op_a),
        .b   (op_b),
        .sel (lg_sel),
        .y   (lg_y)
    );

    // Combinational process: operation select and next held flags.
    always_comb begin
        ex = '0;
        unique case (func)
            FN_ADD: begin
                ex.res = as_sum; ex.writes = 1'b1; ex.defined = 1'b1;
                ex.fl.c = as_cout; ex.fl.v = as_ovf;
            end
            FN_SUB, FN_CMP: begin
                ex.res = as_sum; ex.writes = (func == FN_SUB); ex.defined = 1'b1;
                ex.fl.c = ~as_cout; ex.fl.v = as_ovf;
            end
            FN_AND, FN_OR, FN_XOR: begin
                ex.res = lg_y; ex.writes = 1'b1; ex.defined = 1'b1;
            end
            FN_MUL: begin
                ex.res = mul_lo; ex.writes = 1'b1; ex.defined = 1'b1;
                ex.fl.v = mul_ovf;
            end
            default: ex = '0;
        endcase
        if (ex.defined) begin
            ex.fl.z = (ex.res == '0);
            ex.fl.n = ex.res[W-1];
        end
        flags_d = (exec_en && ex.defined) ? ex.fl : flg_q;
    end

    // Sequential process: the flag holder.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flg_q <= '0;
        else        flg_q <= flags_d;
    end

    assign result    = ex.res;
    assign wr_en     = exec_en && ex.writes;
    assign flags_now = ex.fl;
    assign flags_q   = flg_q;
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
    parameter int W = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic         exec_en,
    input logic [3:0]   func,
    input logic [W-1:0] result,
    input logic         wr_en,
    input logic [3:0]   flags_now,
    input logic [3:0]   flags_q
);
    logic known;
    logic bitwise;
    assign known   = (func <= 4'h5) || (func == 4'h7);
    assign bitwise = (func == 4'h2) || (func == 4'h3) || (func == 4'h4);

    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (func == 4'h7) |-> !wr_en);

    a_r7_write_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en || !known) |-> !wr_en);

    a_r3_bitwise_cv_clear: assert property (@(posedge clk) disable iff (!rst_n)
        bitwise |-> (flags_now[3:2] == 2'b00));

    a_r6_zn_follow_result: assert property (@(posedge clk) disable iff (!rst_n)
        known |-> (flags_now[0] == (result == '0)) && (flags_now[1] == result[W-1]));

    a_r8_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && known) |=> (flags_q == $past(flags_now)));

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec_en || !known) |=> $stable(flags_q));

    a_r9_undefined_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !known |-> (result == '0) && (flags_now == 4'h0));

    a_r10_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (flags_q == 4'h0));
endmodule

bind nib_alu nib_alu_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_en   (exec_en),
    .func      (func),
    .result    (result),
    .wr_en     (wr_en),
    .flags_now (flags_now),
    .flags_q   (flags_q)
);

// File: tb/nib_alu_bench.sv
module nib_alu_bench;
    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         exec_en = 1'b0;
    logic [3:0]   func = '0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         wr_en;
    logic [3:0]   flags_now;
    logic [3:0]   flags_q;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;
    int exp_q = 0;
    string q_tag = "R10";

    always #2.5 clk = ~clk;

    nib_alu #(.W(W)) u_nib_alu (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .func(func),
        .op_a(op_a), .op_b(op_b), .result(result), .wr_en(wr_en),
        .flags_now(flags_now), .flags_q(flags_q)
    );

    task automatic check(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (func=%0h a=%0h b=%0h)",
                     tag, act, expv, func, op_a, op_b);
        end
    endtask

    function automatic int sx(input int v);
        return (v >= 8) ? v - 16 : v;
    endfunction

    function automatic int fits(input int v);
        return (v >= -8 && v <= 7) ? 1 : 0;
    endfunction

    // Reference model: returns {defined, writes, V, C, N, Z, res[3:0]}.
    function automatic int model(input int f, input int a, input int b);
        int r, c, v, def, wr, p;
        def = 1; wr = 1; c = 0; v = 0; r = 0;
        case (f)
            0: begin r = (a + b) & 15; c = (a + b > 15); v = !fits(sx(a) + sx(b)); end
            1, 7: begin r = (a - b) & 15; c = (a < b); v = !fits(sx(a) - sx(b)); wr = (f == 1); end
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: begin p = sx(a) * sx(b); r = p & 15; v = !fits(p); end
            default: begin def = 0; wr = 0; end
        endcase
        if (!def) return 0;
        return (def << 9) | (wr << 8) | (v << 7) | (c << 6) |
               (((r >> 3) & 1) << 5) | ((r == 0) << 4) | r;
    endfunction

    function automatic string tag_of(input int f);
        case (f)
            0: return "R1";
            1: return "R2";
            2, 3, 4: return "R3";
            5: return "R4";
            7: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic step(input int f, input int a, input int b, input bit e);
        int m, fl;
        @(negedge clk);
        check(q_tag, flags_q, exp_q);
        func = f[3:0]; op_a = a[3:0]; op_b = b[3:0]; exec_en = e;
        #1;
        m = model(f, a, b);
        fl = (m >> 4) & 15;
        check(tag_of(f), result, m & 15);
        check(tag_of(f), flags_now[3:2], fl >> 2);
        check(((m >> 9) & 1) ? "R6" : "R9", flags_now[1:0], fl & 3);
        check("R7", wr_en, e && ((m >> 8) & 1));
        if (e && ((m >> 9) & 1)) begin
            exp_q = fl; q_tag = "R8";
        end else begin
            q_tag = "R9";
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10", flags_q, 0);
        rst_n = 1'b1;
        for (int f = 0; f < 16; f++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++)
                    step(f, a, b, ((a * 3 + b + f) % 5) != 0);
        // Final held-flags check after the last edge.
        step(6, 0, 0, 1'b0);
        // Reset mid-run clears the held flags.
        step(1, 0, 1, 1'b1);
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10", flags_q, 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule